// File: doc/BRIEF.md
# Wide-Register Control/Status Bus Multiplexer

This block sits between a narrow control/status bus master and a fixed set of register elements. Each element can be wider than the bus data path, and each is read-only, write-only or read-write. The bus master presents an address with a one-cycle read strobe and/or write strobe. The block decodes the address, steers the access to the element that owns it, and returns read data two clock edges after the strobe.

An element wider than the bus is split into consecutive bus addresses, one data-width chunk per address, with the low chunk at the lowest address. Reads and writes to such an element are atomic. A read of the element's first address captures the whole value into a read shadow, and reads of the higher chunks return bytes from that shadow. Writes to the lower chunks fill a write shadow, and the write to the top chunk delivers the whole assembled value to the element with one commit strobe.

Element placement is fixed at elaboration time by parameter arrays:
- the width of each element,
- the access mode of each element,
- an optional per-element align-to request,
- a global alignment exponent.

Top module: `csr_wide_mux`

## Requirements
- R1: An element of width W occupies C = ceil(W / DATA_W) data chunks, with C = 1 for a zero-width element. The element's write commit happens at its chunk C-1.
- R2: Elements are placed in index order, each one at the next free address. Each element's span is C rounded up to a multiple of 2^ALIGN. With defaults (widths 4,8,16,20,12; ALIGN=1; element 3 align-to 4) the bases are 0, 2, 4, 16 and 20.
- R3: An align-to value n moves an element's base up to a multiple of 2^max(n, ALIGN). A value below ALIGN therefore has no extra effect.
- R4: A read strobe at an element's base address raises that element's read strobe for the cycle after the sampling edge. The same edge captures the element's value, masked to its width, into the read shadow. Chunk 0 of that snapshot appears on bus read data after the following edge.
- R5: A read strobe at chunk k > 0 returns bits [8k+7:8k] (for DATA_W=8) of the last snapshot, with the same two-edge latency. It pulses no strobe and takes no new snapshot.
- R6: A write to a chunk below C-1 only updates the write shadow. A write to chunk C-1 pulses the element's write strobe for one cycle. The element's write data then holds the assembled value (write data at the top chunk, shadow below) until the next commit.
- R7: Bits of the top chunk above the element width are dropped from the committed value. For example, writes of 0x55, 0xAA, 0x33 to a 20-bit element commit 0x3AA55.
- R8: Padding addresses inside a span (chunk index ≥ C) ignore writes, pulse nothing, and read as zero.
- R9: Mode encoding is bit0 = readable and bit1 = writable (1 = read-only, 2 = write-only, 3 = read-write). A read-only element never pulses its write strobe and its write data stays zero. A write-only element never pulses its read strobe and reads as zero.
- R10: Accesses to unmapped addresses change nothing and read as zero. Bus read data is zero in every cycle that does not follow a read stage.
- R11: All element strobes are registered one-cycle pulses. At most one element's read strobe and at most one element's write strobe are high in any cycle.
- R12: Synchronous active-high reset clears bus read data, all element strobes, all element write data and all shadows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_rstb | input | 1 | Bus read strobe |
| bus_wstb | input | 1 | Bus write strobe |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Bus read data, registered |
| el_rdata | input | NUM_EL*SLOT_W | Element values, slot g at bits [g*SLOT_W +: SLOT_W] |
| el_rstb | output | NUM_EL | Per-element read strobe |
| el_wdata | output | NUM_EL*SLOT_W | Committed per-element write values |
| el_wstb | output | NUM_EL | Per-element write commit strobe |

## Verification
The bench sweeps every address of the space, both upward and downward. It changes the element values after each snapshot edge, so a design that re-read the live value on a high chunk, or re-snapshotted on it, returns the newer value and is caught. Write sweeps commit each multi-chunk element from partial shadows. A design that committed on every chunk, or on a padding address, would pulse write strobes or corrupt the held value. A design that kept the top chunk's spare bits would fail the 20-bit commit. Placement errors show up as strobes on the wrong element or as data at addresses that should read zero. Mode-gating errors show up as strobes or non-zero data on the read-only and write-only elements.

// File: rtl/csr_mux_pkg.sv
package csr_mux_pkg;

  localparam int MODE_RD = 1;
  localparam int MODE_WR = 2;

  // data chunks an element needs; a zero-width element still takes one
  function automatic int chunk_count(input int width, input int dw);
    if (width <= 0) return 1;
    return (width + dw - 1) / dw;
  endfunction

  // round v up to a multiple of 2**n
  function automatic int round_pow2(input int v, input int n);
    return ((v + (1 << n) - 1) >> n) << n;
  endfunction

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int idx_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/csr_wide_slot.sv
module csr_wide_slot
  import csr_mux_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SLOT_W = 20,
  parameter int WIDTH  = 8,
  parameter int MODE   = 3,
  parameter int BASE   = 0,
  parameter int SPAN   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rstb,
  input  logic              bus_wstb,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [SLOT_W-1:0] el_rdata,
  output logic              el_rstb,
  output logic [SLOT_W-1:0] el_wdata,
  output logic              el_wstb,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_pend
);

  localparam int CHUNKS = chunk_count(WIDTH, DATA_W);
  localparam int SH_W   = CHUNKS * DATA_W;
  localparam int BIG_W  = max_i(SH_W, SLOT_W);
  localparam int IDX_W  = idx_bits(SPAN);
  localparam int LAST   = CHUNKS - 1;
  localparam logic [SLOT_W:0]   ONE_AT = (SLOT_W+1)'(1) << WIDTH;
  localparam logic [SLOT_W-1:0] VMASK  = SLOT_W'(ONE_AT - 1'b1);

  // address decode
  logic [ADDR_W-1:0] offs;
  logic              hit;
  logic              in_data;
  logic [IDX_W-1:0]  cidx;
  logic              is_first;
  logic              is_last;

  assign offs     = bus_addr - ADDR_W'(BASE);
  assign hit      = ({1'b0, bus_addr} >= (ADDR_W+1)'(BASE)) &&
                    ({1'b0, bus_addr} <  (ADDR_W+1)'(BASE + SPAN));
  assign cidx     = offs[IDX_W-1:0];
  assign in_data  = hit && ({1'b0, cidx} < (IDX_W+1)'(CHUNKS));
  assign is_first = (cidx == '0);
  assign is_last  = ({1'b0, cidx} == (IDX_W+1)'(LAST));

  generate
    if ((MODE & MODE_RD) != 0) begin : g_rd
      logic [SH_W-1:0]  shadow;
      logic [IDX_W-1:0] sel;
      logic             pend;
      logic             rstb_q;
      logic [BIG_W-1:0] snap_big;

      assign snap_big = BIG_W'(el_rdata & VMASK);

      always_ff @(posedge clk) begin
        if (rst) begin
          shadow <= '0;
          sel    <= '0;
          pend   <= 1'b0;
          rstb_q <= 1'b0;
        end else begin
          rstb_q <= bus_rstb && in_data && is_first;
          pend   <= bus_rstb && in_data;
          if (bus_rstb && in_data) sel <= cidx;
          if (bus_rstb && in_data && is_first) shadow <= snap_big[SH_W-1:0];
        end
      end

      assign rd_word = pend ? shadow[int'(sel)*DATA_W +: DATA_W] : '0;
      assign rd_pend = pend;
      assign el_rstb = rstb_q;

      // R5
      shadow_only_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (shadow != $past(shadow)) |-> rstb_q);
    end else begin : g_no_rd
      logic unused_rd;
      assign unused_rd = ^{el_rdata, bus_rstb};
      assign rd_word   = '0;
      assign rd_pend   = 1'b0;
      assign el_rstb   = 1'b0;
    end

    if ((MODE & MODE_WR) != 0) begin : g_wr
      logic [SH_W-1:0]   wsh;
      logic [SH_W-1:0]   joined;
      logic [BIG_W-1:0]  joined_big;
      logic [SLOT_W-1:0] wdata_q;
      logic              wstb_q;
      logic              fire;
      logic              commit;

      assign fire   = bus_wstb && in_data;
      assign commit = fire && is_last;

      always_comb begin
        joined = wsh;
        joined[LAST*DATA_W +: DATA_W] = bus_wdata;
      end
      assign joined_big = BIG_W'(joined);

      always_ff @(posedge clk) begin
        if (rst) begin
          wsh     <= '0;
          wdata_q <= '0;
          wstb_q  <= 1'b0;
        end else begin
          wstb_q <= commit;
          if (fire && !commit) wsh[int'(cidx)*DATA_W +: DATA_W] <= bus_wdata;
          if (commit) wdata_q <= joined_big[SLOT_W-1:0] & VMASK;
        end
      end

      assign el_wdata = wdata_q;
      assign el_wstb  = wstb_q;

      // R6
      wdata_changes_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (wdata_q != $past(wdata_q)) |-> wstb_q);

      // R7
      wdata_within_width_chk: assert property (@(posedge clk) disable iff (rst)
        (wdata_q & ~VMASK) == '0);
    end else begin : g_no_wr
      logic unused_wr;
      assign unused_wr = ^{bus_wdata, bus_wstb};
      assign el_wdata  = '0;
      assign el_wstb   = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/csr_rd_merge.sv
module csr_rd_merge #(
  parameter int NUM_EL = 5,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_EL*DATA_W-1:0] words,
  input  logic [NUM_EL-1:0]        pend,
  output logic [DATA_W-1:0]        bus_rdata
);

  logic [DATA_W-1:0] merged;

  always_comb begin
    merged = '0;
    for (int i = 0; i < NUM_EL; i++) merged = merged | words[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= merged;
  end

  // R11
  single_read_source_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pend));

  // R10
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> (bus_rdata == '0));

endmodule

// File: rtl/csr_wide_mux.sv
module csr_wide_mux
  import csr_mux_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int NUM_EL = 5,
  parameter int SLOT_W = 20,
  parameter int ALIGN  = 1,
  parameter int EL_WIDTH    [NUM_EL] = '{4, 8, 16, 20, 12},
  parameter int EL_MODE     [NUM_EL] = '{1, 2, 3, 3, 1},
  parameter int EL_ALIGN_TO [NUM_EL] = '{0, 0, 0, 4, 0}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_rstb,
  input  logic                     bus_wstb,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NUM_EL*SLOT_W-1:0] el_rdata,
  output logic [NUM_EL-1:0]        el_rstb,
  output logic [NUM_EL*SLOT_W-1:0] el_wdata,
  output logic [NUM_EL-1:0]        el_wstb
);

  // compile-time placement: in order, each base aligned, span padded
  function automatic int place_base(input int idx);
    int cur;
    int res;
    cur = 0;
    res = 0;
    for (int i = 0; i < NUM_EL; i++) begin
      cur = round_pow2(cur, max_i(ALIGN, EL_ALIGN_TO[i]));
      if (i == idx) res = cur;
      cur = cur + round_pow2(chunk_count(EL_WIDTH[i], DATA_W), ALIGN);
    end
    return res;
  endfunction

  logic [NUM_EL*DATA_W-1:0] words;
  logic [NUM_EL-1:0]        pend;

  generate
    for (genvar g = 0; g < NUM_EL; g++) begin : g_el
      localparam int BASE = place_base(g);
      localparam int SPAN = round_pow2(chunk_count(EL_WIDTH[g], DATA_W), ALIGN);

      csr_wide_slot #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SLOT_W (SLOT_W),
        .WIDTH  (EL_WIDTH[g]),
        .MODE   (EL_MODE[g]),
        .BASE   (BASE),
        .SPAN   (SPAN)
      ) u_slot (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rstb  (bus_rstb),
        .bus_wstb  (bus_wstb),
        .bus_wdata (bus_wdata),
        .el_rdata  (el_rdata[g*SLOT_W +: SLOT_W]),
        .el_rstb   (el_rstb[g]),
        .el_wdata  (el_wdata[g*SLOT_W +: SLOT_W]),
        .el_wstb   (el_wstb[g]),
        .rd_word   (words[g*DATA_W +: DATA_W]),
        .rd_pend   (pend[g])
      );
    end
  endgenerate

  csr_rd_merge #(
    .NUM_EL (NUM_EL),
    .DATA_W (DATA_W)
  ) u_merge (
    .clk       (clk),
    .rst       (rst),
    .words     (words),
    .pend      (pend),
    .bus_rdata (bus_rdata)
  );

  // R11
  one_read_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(el_rstb));

  // R11
  one_write_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(el_wstb));

  // R4
  rstb_needs_bus_read_chk: assert property (@(posedge clk) disable iff (rst)
    (el_rstb != '0) |-> $past(bus_rstb));

  // R6
  wstb_needs_bus_write_chk: assert property (@(posedge clk) disable iff (rst)
    (el_wstb != '0) |-> $past(bus_wstb));

endmodule

// File: tb/csr_wide_mux_bench.sv
module csr_wide_mux_bench;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NE = 5;
  localparam int SW = 20;

  // expected placement derived by hand from R1-R3 for the default configuration
  localparam int WID  [NE] = '{4, 8, 16, 20, 12};
  localparam int MODE [NE] = '{1, 2, 3, 3, 1};
  localparam int BASE [NE] = '{0, 2, 4, 16, 20};
  localparam int CHK  [NE] = '{1, 1, 2, 3, 2};
  localparam int SPAN [NE] = '{2, 2, 2, 4, 2};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [AW-1:0]     bus_addr = '0;
  logic              bus_rstb = 1'b0;
  logic              bus_wstb = 1'b0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic [NE*SW-1:0]  el_rdata;
  logic [NE-1:0]     el_rstb;
  logic [NE*SW-1:0]  el_wdata;
  logic [NE-1:0]     el_wstb;

  logic [SW-1:0] rval     [NE];
  logic [SW-1:0] exp_snap [NE];
  logic [31:0]   exp_wsh  [NE];
  logic [SW-1:0] exp_wd   [NE];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NE; i++) el_rdata[i*SW +: SW] = rval[i];
  end

  csr_wide_mux u_csr_wide_mux (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rstb  (bus_rstb),
    .bus_wstb  (bus_wstb),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .el_rdata  (el_rdata),
    .el_rstb   (el_rstb),
    .el_wdata  (el_wdata),
    .el_wstb   (el_wstb)
  );

  function automatic logic [SW-1:0] wmask(input int w);
    if (w >= SW) return '1;
    return SW'((32'd1 << w) - 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      fails++;
      $display("FAIL R12 watchdog actual=%0d cycles expected=<50000", cyc);
      summary();
      $finish;
    end
  end

  // locate address: e = -1 when unmapped
  task automatic locate(input int a, output int e, output int ch);
    e = -1;
    ch = 0;
    for (int i = 0; i < NE; i++)
      if (a >= BASE[i] && a < BASE[i] + SPAN[i]) begin
        e = i;
        ch = a - BASE[i];
      end
  endtask

  task automatic check_wdata(input string req);
    for (int i = 0; i < NE; i++)
      check(((MODE[i] & 2) == 0) ? "R9 read-only wdata" : req,
            32'(el_wdata[i*SW +: SW]), 32'(exp_wd[i]));
  endtask

  task automatic do_read(input int a);
    int e;
    int ch;
    logic [NE-1:0] exp_r;
    logic [31:0]   exp_d;
    string tag;
    locate(a, e, ch);
    exp_r = '0;
    exp_d = '0;
    tag = "R10 unmapped";
    if (e >= 0) begin
      if (ch >= CHK[e])                 tag = "R8 padding";
      else if ((MODE[e] & 1) == 0)      tag = "R9 write-only";
      else begin
        tag = (ch == 0) ? "R4" : "R5";
        if (ch == 0) begin
          exp_r[e] = 1'b1;
          exp_snap[e] = rval[e] & wmask(WID[e]);
        end
        exp_d = (32'(exp_snap[e]) >> (8 * ch)) & 32'hff;
      end
    end
    @(negedge clk);
    bus_addr = AW'(a);
    bus_rstb = 1'b1;
    @(negedge clk);
    bus_rstb = 1'b0;
    check((e == 3) ? "R3 align-to strobe" : "R2 placement strobe", 32'(el_rstb), 32'(exp_r));
    // perturb live values so a stale-vs-live mix-up shows up
    for (int i = 0; i < NE; i++) rval[i] = rval[i] * 5 + SW'(20'h1357 + i);
    @(negedge clk);
    check(tag, 32'(bus_rdata), exp_d);
    check("R11 strobe one cycle", 32'(el_rstb), 32'd0);
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    int e;
    int ch;
    logic [NE-1:0] exp_w;
    logic [31:0]   full;
    string tag;
    locate(a, e, ch);
    exp_w = '0;
    tag = "R6";
    if (e >= 0 && ch < CHK[e] && (MODE[e] & 2) != 0) begin
      if (ch == CHK[e] - 1) begin
        full = exp_wsh[e];
        full[8*ch +: 8] = d;
        exp_wd[e] = full[SW-1:0] & wmask(WID[e]);
        exp_w[e] = 1'b1;
        if (e == 3) tag = "R7";
      end else begin
        exp_wsh[e][8*ch +: 8] = d;
      end
    end else if (e >= 0 && ch >= CHK[e]) tag = "R8 padding write";
    else if (e < 0) tag = "R10 unmapped write";
    @(negedge clk);
    bus_addr  = AW'(a);
    bus_wdata = d;
    bus_wstb  = 1'b1;
    @(negedge clk);
    bus_wstb = 1'b0;
    check("R1 commit chunk", 32'(el_wstb), 32'(exp_w));
    check_wdata(tag);
    @(negedge clk);
    check("R11 strobe one cycle", 32'(el_wstb), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) begin
      rval[i]     = SW'(20'hA5C3B + i * 20'h1F0D3);
      exp_snap[i] = '0;
      exp_wsh[i]  = '0;
      exp_wd[i]   = '0;
    end
    repeat (3) @(negedge clk);
    check("R12 reset rdata", 32'(bus_rdata), 32'd0);
    check("R12 reset strobes", 32'({el_rstb, el_wstb}), 32'd0);
    check_wdata("R12 reset wdata");
    rst = 1'b0;

    for (int a = 0; a < 64; a++) do_read(a);
    for (int a = 63; a >= 0; a--) do_read(a);
    for (int a = 0; a < 64; a++) do_write(a, 8'(a * 37 + 11));
    for (int a = 63; a >= 0; a--) do_write(a, 8'(a * 91 + 200));

    // R7: three chunk writes to the 20-bit element
    do_write(16, 8'h55);
    do_write(17, 8'hAA);
    do_write(18, 8'h33);
    check("R7 top chunk trimmed", 32'(el_wdata[3*SW +: SW]), 32'h3AA55);

    // R5: back-to-back reads of the 16-bit element, 0x5AA5
    rval[2] = 20'h05AA5;
    @(negedge clk);
    bus_addr = 6'd4;
    bus_rstb = 1'b1;
    @(negedge clk);
    bus_addr = 6'd5;
    check("R4 pipelined strobe", 32'(el_rstb), 32'h4);
    rval[2] = 20'h0FFFF;
    @(negedge clk);
    bus_rstb = 1'b0;
    check("R4 pipelined low chunk", 32'(bus_rdata), 32'hA5);
    check("R5 no strobe on high chunk", 32'(el_rstb), 32'd0);
    @(negedge clk);
    check("R5 pipelined high chunk", 32'(bus_rdata), 32'h5A);
    @(negedge clk);
    check("R10 idle rdata", 32'(bus_rdata), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule